// File: doc/BRIEF.md
# Ten-Minute Window Alarm Matcher

This block watches a running twelve-hour time of day and raises an alarm when that time enters a window picked by the user. The user setting is one 8-bit word. It names an hour, a minutes tens digit and a half of the day. Minutes units and seconds play no part in the comparison. The window is therefore ten minutes long. For example, a setting of 4:30 PM matches from 4:30:00 to 4:39:59.

The match stays true for the whole window, so the alarm does not follow its level. The alarm turns on when the match goes from false to true. It then holds until a silence request clears it. Clearing the alarm while the window is still open does not start it again; only a fresh entry into a matching window does. The output drives a buzzer driver. The silence input is taken as already synchronised, and it may be a pulse or a level.

Top module: `alarm_window_matcher`

## Requirements
- R1: The setting word is decoded as follows: bits [7:4] hold the binary hour (1 to 12), bits [3:1] hold the minutes tens digit (0 to 5), and bit [0] holds the half of the day, with 1 meaning AM and 0 meaning PM.
- R2: A match needs the hour, the minutes tens digit and the half-of-day bit all to equal the setting. A difference in any one of these fields alone never raises the alarm.
- R3: When the match goes from false to true, `alarm_on` is high after the next rising clock edge.
- R4: Once high, `alarm_on` stays high while `silence` is low, even after the match has become false.
- R5: A clock edge with `silence` high leaves `alarm_on` low.
- R6: After the alarm is silenced while the match is still true, it stays low until the match has gone false and then true again.
- R7: Reset (active-low `rst_n`) forces `alarm_on` low. A match that is already present when reset ends does not raise the alarm until the match has first been seen false.
- R8: If `silence` is high in the same cycle as a new rising match, `alarm_on` stays low. That rising match is used up and does not trigger the alarm later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alarm_set | input | 8 | User alarm setting: hour [7:4], minutes tens [3:1], AM flag [0] |
| hour_bin | input | 4 | Current hour in binary, 1 to 12 |
| min_tens | input | 3 | Current minutes tens digit, 0 to 5 |
| is_am | input | 1 | Current half of day, 1 for AM |
| silence | input | 1 | Synchronised request to clear the alarm |
| alarm_on | output | 1 | Alarm active, to the buzzer driver |

## Verification
The hardest cases are a match that already holds when reset ends and a silence request that falls inside an open window. Neither case comes from the normal passing of time. To reach them, the bench holds the live time equal to the setting through reset and release. It then stays on a matching time while it pulses `silence`, including one pulse in the same cycle as a fresh entry into the window. After that, it leaves the window and enters it again to show that a real new edge still raises the alarm.

// File: rtl/amw_pkg.sv
// Package: alarm_window_matcher shared widths and the time-slot record.
// Assumes a twelve-hour clock: binary hour, minutes tens digit, AM flag.
package amw_pkg;
    localparam int HOUR_W_DEF = 4;
    localparam int TENS_W_DEF = 3;

    // One ten-minute slot of the day, packed in setting-word order.
    typedef struct packed {
        logic [HOUR_W_DEF-1:0] hour;
        logic [TENS_W_DEF-1:0] tens;
        logic                  am;
    } slot_t;

    localparam int SLOT_W = $bits(slot_t);
endpackage

// File: rtl/amw_slot_cmp.sv
// Module: amw_slot_cmp
// Equality of two packed slot words, bit by bit, then reduced.
// Assumes both words use the same field layout. Purely combinational.
module amw_slot_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] slot_a,
    input  logic [W-1:0] slot_b,
    output logic         same
);
    logic [W-1:0] bit_eq;

    // Per-bit agreement, one XNOR for each position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_eq[i] = ~(slot_a[i] ^ slot_b[i]);
    end

    // Match only when every position agrees.
    assign same = &bit_eq;
endmodule

// File: rtl/amw_edge_arm.sv
// Module: amw_edge_arm
// Finds the rising edge of a level match. The edge counts only after
// the match has been seen low at least once since reset.
// Assumes a synchronous active-low reset.
module amw_edge_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    output logic match_q,
    output logic armed,
    output logic rise
);
    // Keep the previous match level and note the first low match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            armed   <= 1'b0;
        end else begin
            match_q <= match;
            if (!match) armed <= 1'b1;
        end
    end

    // Fresh edge: high now, low last cycle, and the window was seen closed.
    assign rise = match & ~match_q & armed;
endmodule

// File: rtl/amw_hold.sv
// Module: amw_hold
// Set/clear register for the alarm. Clear has priority over set.
// Assumes a synchronous active-low reset.
module amw_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr,
    output logic held
);
    // Latch on a set pulse and drop on clear; clear wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)     held <= 1'b0;
        else if (clr)   held <= 1'b0;
        else if (set_pulse) held <= 1'b1;
    end
endmodule

// File: rtl/alarm_window_matcher.sv
// Module: alarm_window_matcher (top)
// Compares the live hour, minutes tens digit and AM flag against the user
// setting. The alarm turns on at the entry into a matching ten-minute
// window and holds until silenced. Assumes silence is already synchronised.
module alarm_window_matcher #(
    parameter int HOUR_W = amw_pkg::HOUR_W_DEF,
    parameter int TENS_W = amw_pkg::TENS_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [HOUR_W+TENS_W:0]     alarm_set,
    input  logic [HOUR_W-1:0]          hour_bin,
    input  logic [TENS_W-1:0]          min_tens,
    input  logic                       is_am,
    input  logic                       silence,
    output logic                       alarm_on
);
    localparam int SW = HOUR_W + TENS_W + 1;

    logic [SW-1:0] live_slot;
    logic          match;
    logic          match_q;
    logic          armed;
    logic          rise;

    // Live time packed in the same order as the setting word.
    assign live_slot = {hour_bin, min_tens, is_am};

    amw_slot_cmp #(.W(SW)) u_cmp (
        .slot_a (alarm_set),
        .slot_b (live_slot),
        .same   (match)
    );

    amw_edge_arm u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .match   (match),
        .match_q (match_q),
        .armed   (armed),
        .rise    (rise)
    );

    amw_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (rise),
        .clr       (silence),
        .held      (alarm_on)
    );
endmodule

// File: rtl/amw_checker.sv
// Module: amw_checker
// Temporal checks on alarm_window_matcher, attached with bind below.
module amw_checker (
    input logic clk,
    input logic rst_n,
    input logic match,
    input logic match_q,
    input logic armed,
    input logic silence,
    input logic alarm_on
);
    // R3: a fresh, armed edge with no silence turns the alarm on.
    assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !match_q && armed && !silence) |=> alarm_on);

    // R4: the alarm holds while there is no silence request.
    assert_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_on && !silence) |=> alarm_on);

    // R5 and R8: silence always leaves the alarm low.
    assert_silence_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        silence |=> !alarm_on);

    // R6: a match that was already high cannot turn the alarm on.
    assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_on && match && match_q) |=> !alarm_on);

    // R7: until the match has been seen low, the alarm stays off.
    assert_unarmed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_on && !armed) |=> !alarm_on);

    // R2: the alarm only turns on when the window is open.
    assert_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_on) |-> $past(match));
endmodule

bind alarm_window_matcher amw_checker u_amw_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .match    (match),
    .match_q  (match_q),
    .armed    (armed),
    .silence  (silence),
    .alarm_on (alarm_on)
);

// File: tb/alarm_window_matcher_test.sv
// Directed bench for alarm_window_matcher. One task per scenario.
module alarm_window_matcher_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] alarm_set = 8'h00;
    logic [3:0] hour_bin = 4'd1;
    logic [2:0] min_tens = 3'd0;
    logic       is_am = 1'b1;
    logic       silence = 1'b0;
    logic       alarm_on;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    alarm_window_matcher uut (
        .clk(clk), .rst_n(rst_n), .alarm_set(alarm_set),
        .hour_bin(hour_bin), .min_tens(min_tens), .is_am(is_am),
        .silence(silence), .alarm_on(alarm_on)
    );

    // Setting word per R1: hour [7:4], tens [3:1], AM flag [0].
    function automatic logic [7:0] mk_set(input int h, input int t, input logic am);
        return {h[3:0], t[2:0], am};
    endfunction

    // Apply inputs at the falling edge, then sample 1 ns after the rising edge.
    task automatic step(input int h, input int t, input logic am, input logic sil);
        @(negedge clk);
        hour_bin = h[3:0]; min_tens = t[2:0]; is_am = am; silence = sil;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: alarm_on=%0b expected %0b", tag, act, exp);
        end
    endtask

    // R7: match held through reset and release stays quiet until seen low.
    task automatic t_reset_with_match();
        alarm_set = mk_set(7, 3, 1'b1);
        rst_n = 1'b0;
        step(7, 3, 1'b1, 1'b0);
        step(7, 3, 1'b1, 1'b0);
        check(alarm_on, 1'b0, "R7 reset state");
        @(negedge clk); rst_n = 1'b1;
        step(7, 3, 1'b1, 1'b0);
        step(7, 3, 1'b1, 1'b0);
        check(alarm_on, 1'b0, "R7 match at release");
        step(7, 2, 1'b1, 1'b0);
        check(alarm_on, 1'b0, "R7 window closed");
        step(7, 3, 1'b1, 1'b0);
        check(alarm_on, 1'b1, "R7 fires after seen low (R3)");
        step(7, 2, 1'b1, 1'b1);
        check(alarm_on, 1'b0, "R5 silence");
    endtask

    // R2: each field wrong on its own never raises the alarm.
    task automatic t_single_field_miss();
        alarm_set = mk_set(7, 3, 1'b1);
        step(8, 3, 1'b1, 1'b0); step(8, 3, 1'b1, 1'b0);
        check(alarm_on, 1'b0, "R2 hour differs");
        step(7, 4, 1'b1, 1'b0); step(7, 4, 1'b1, 1'b0);
        check(alarm_on, 1'b0, "R2 tens differs");
        step(7, 3, 1'b0, 1'b0); step(7, 3, 1'b0, 1'b0);
        check(alarm_on, 1'b0, "R2 meridiem differs");
    endtask

    // R3, R4: fire at entry, hold after leaving the window, then silence (R5).
    task automatic t_fire_and_hold();
        alarm_set = mk_set(4, 3, 1'b0);
        step(4, 2, 1'b0, 1'b0);
        step(4, 3, 1'b0, 1'b0);
        check(alarm_on, 1'b1, "R3 entry into window");
        step(4, 4, 1'b0, 1'b0);
        step(5, 0, 1'b0, 1'b0);
        step(5, 0, 1'b0, 1'b0);
        check(alarm_on, 1'b1, "R4 held after window");
        step(5, 0, 1'b0, 1'b1);
        check(alarm_on, 1'b0, "R5 silence clears");
        step(5, 0, 1'b0, 1'b0);
        check(alarm_on, 1'b0, "R5 stays clear");
    endtask

    // R6: silence inside an open window; a real new edge still fires.
    task automatic t_silence_in_window();
        alarm_set = mk_set(12, 5, 1'b0);
        step(11, 5, 1'b0, 1'b0);
        step(12, 5, 1'b0, 1'b0);
        check(alarm_on, 1'b1, "R1 12:50 PM layout");
        step(12, 5, 1'b0, 1'b1);
        step(12, 5, 1'b0, 1'b0);
        step(12, 5, 1'b0, 1'b0);
        check(alarm_on, 1'b0, "R6 no retrigger in window");
        step(1, 0, 1'b0, 1'b0);
        step(12, 5, 1'b0, 1'b0);
        check(alarm_on, 1'b1, "R6 new edge fires");
        step(1, 0, 1'b0, 1'b1);
    endtask

    // R8: silence in the same cycle as the rising match wins.
    task automatic t_silence_tie();
        alarm_set = mk_set(9, 0, 1'b1);
        step(8, 5, 1'b1, 1'b0);
        step(9, 0, 1'b1, 1'b1);
        check(alarm_on, 1'b0, "R8 tie silenced");
        step(9, 0, 1'b1, 1'b0);
        step(9, 0, 1'b1, 1'b0);
        check(alarm_on, 1'b0, "R8 edge consumed");
    endtask

    // R1: a setting that exchanges the AM flag with the low tens bit does not match.
    task automatic t_layout_order();
        alarm_set = 8'b0110_011_1;   // 6:30 AM
        step(6, 2, 1'b1, 1'b0);
        step(6, 3, 1'b1, 1'b0);
        check(alarm_on, 1'b1, "R1 6:30 AM decoded");
        step(6, 4, 1'b1, 1'b1);
        alarm_set = 8'b0110_010_1;   // 6:20 AM, live 6:30 AM
        step(6, 3, 1'b1, 1'b0);
        step(6, 3, 1'b1, 1'b0);
        check(alarm_on, 1'b0, "R1 tens field position");
    endtask

    initial begin
        t_reset_with_match();
        t_single_field_miss();
        t_fire_and_hold();
        t_silence_in_window();
        t_silence_tie();
        t_layout_order();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #200000;
        vectors++;
        miscompares++;
        $display("FAIL watchdog: done=0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule